// File: doc/BRIEF.md
# Dual Down-Counter Timer Block

This block holds two independent 32-bit down-counting timer channels behind one register window. The window spans 4 KB and is addressed with a 12-bit byte address. Each channel counts down once per prescaled tick of its own tick-enable input, so the two channels can run from different base rates. The default base rate for both is a 1 MHz enable. A channel can run free, run periodically from a programmed limit, or run once. When its count expires, it raises a latched interrupt flag.

Software reaches each channel through a small bank of registers: limit, current count, control, interrupt clear, raw status, masked status and a background limit. The top 32 bytes of the window hold a fixed sequence of identification bytes. Two integration-test locations read as zero. The masked interrupts of both channels are ORed onto one interrupt line.

The register port is a plain synchronous one. A write takes effect at the clock edge on which the write strobe is sampled. Read data appears on the clock edge that samples the read strobe, and it holds until the next read.

Top module: `dual_timer_top`

## Requirements
- R1: After reset, each channel reads control 0x20 (interrupt enabled, stopped), count 0, limit 0, raw status 0, and the interrupt output is low.
- R2: Byte offsets 0x000–0x01F select channel 0 and 0x020–0x03F select channel 1. The local word offsets are: 0x00 limit (write reloads), 0x04 count (read-only), 0x08 control, 0x0C interrupt clear (write-only), 0x10 raw status in bit 0, 0x14 masked status in bit 0, 0x18 background limit. Local offset 0x1C reads 0.
- R3: Control bits are: 7 enable, 6 periodic, 5 interrupt enable, 3:2 prescale, 1 wide, 0 one-shot. Writing the limit reloads the count. The reload value is the limit, or all ones of the counter width when both periodic and one-shot are clear. Writing control with enable set performs the same reload. Writing the background limit changes only the stored limit.
- R4: An enabled channel decrements once per prescaled tick of its own tick input. Prescale code 0 gives 1 tick per step, 1 gives 16, 2 gives 256 and 3 gives 1. The prescaler restarts on every control write. A stopped channel holds its count.
- R5: A prescaled tick at count 1 takes the count to 0 and sets the raw flag. The next tick at count 0 reloads the limit (periodic), reloads all ones (free-running), or leaves the count at 0 (one-shot).
- R6: With the wide bit clear, the counter is 16 bits: count bits 31:16 always read 0 and the all-ones reload is 0xFFFF. With the wide bit set, it is 0xFFFFFFFF.
- R7: Any write to the clear offset clears the raw flag. The masked status is the raw flag ANDed with control bit 5. The interrupt output is the OR of both channels' masked status.
- R8: Offsets 0xFE0–0xFFC return one identification byte each in bits 7:0, with bits 31:8 zero. The bytes, from the lowest offset up, are 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Offsets 0xF00 and 0xF04, and every other unmapped offset, read 0. Writes at offset 0x040 or above change nothing.
- R10: Read data is registered on the edge that samples the read strobe and holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 2 | Per-channel base tick enable, bit n for channel n |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt (OR of masked channel interrupts) |

## Verification
Some properties are checked on every cycle by assertions:
- the narrow-mode upper count bits stay zero;
- an expiry always leaves the raw flag set;
- a one-shot channel at zero stays there;
- a stopped channel holds its count;
- read data stays stable between reads;
- identification and unmapped reads carry no stray upper bits;
- high-offset writes leave every channel's control and limit untouched.

The bench scenarios show what needs chosen sequences. These are the exact tick counts each prescale setting needs per step, and the reload values in periodic, free-running and one-shot modes. They also cover the reload value a limit write gives in free-running mode, the identification byte order, and the OR of the two interrupts as each one is cleared.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int CNT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int CTRL_W   = 8;

  // control bit positions (software decodes these)
  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PSC_LO   = 2;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_EN       = 7;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

  typedef enum logic [2:0] {
    REG_LIMIT  = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_ICLR   = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_BGLIM  = 3'd6,
    REG_NONE   = 3'd7
  } chan_reg_e;

  // restrict a count to the active width
  function automatic logic [CNT_W-1:0] fit_width(input logic [CNT_W-1:0] v,
                                                 input logic wide);
    if (wide) return v;
    return {{(CNT_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
  endfunction

  // value loaded into the counter on a reload event
  function automatic logic [CNT_W-1:0] reload_value(input logic [CTRL_W-1:0] ctrl,
                                                    input logic [CNT_W-1:0] lim);
    logic free_run;
    free_run = !ctrl[CB_ONESHOT] && !ctrl[CB_PERIODIC];
    if (free_run) return fit_width({CNT_W{1'b1}}, ctrl[CB_WIDE]);
    return fit_width(lim, ctrl[CB_WIDE]);
  endfunction

  // identification byte sequence
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h04;
      3'd1: return 8'h18;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       pulse_o
);

  logic [PW-1:0] cnt_q;

  always_comb begin
    case (sel_i)
      2'd1:    pulse_o = tick_i && (cnt_q[3:0] == 4'hF);
      2'd2:    pulse_o = tick_i && (&cnt_q);
      default: pulse_o = tick_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  chan_reg_e         sel_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  limit_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  limit_q;
  logic [CNT_W-1:0]  count_q;
  logic              raw_q;

  // named events
  logic limit_wr, ctrl_wr, clr_wr, bglim_wr;
  logic psc_pulse, dec_tick, expire_ev;
  logic at_zero;

  assign limit_wr = wr_i && (sel_i == REG_LIMIT);
  assign ctrl_wr  = wr_i && (sel_i == REG_CTRL);
  assign clr_wr   = wr_i && (sel_i == REG_ICLR);
  assign bglim_wr = wr_i && (sel_i == REG_BGLIM);
  assign at_zero  = (count_q == '0);

  tmr_prescale #(.PW(8)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ctrl_wr),
    .tick_i  (tick_i),
    .sel_i   (ctrl_q[CB_PSC_LO +: 2]),
    .pulse_o (psc_pulse)
  );

  assign dec_tick  = psc_pulse && ctrl_q[CB_EN] && !limit_wr && !ctrl_wr;
  assign expire_ev = dec_tick && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      limit_q <= '0;
      count_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (limit_wr || bglim_wr) limit_q <= wdata_i;
      if (limit_wr) begin
        count_q <= reload_value(ctrl_q, wdata_i);
      end else if (ctrl_wr) begin
        if (wdata_i[CB_EN]) count_q <= reload_value(wdata_i[CTRL_W-1:0], limit_q);
        else                count_q <= fit_width(count_q, wdata_i[CB_WIDE]);
      end else if (dec_tick) begin
        if (!at_zero)                count_q <= count_q - 1'b1;
        else if (!ctrl_q[CB_ONESHOT]) count_q <= reload_value(ctrl_q, limit_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         raw_q <= 1'b0;
    else if (expire_ev) raw_q <= 1'b1;
    else if (clr_wr)    raw_q <= 1'b0;
  end

  always_comb begin
    case (sel_i)
      REG_LIMIT, REG_BGLIM: rdata_o = limit_q;
      REG_COUNT:            rdata_o = count_q;
      REG_CTRL:             rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      REG_RAW:              rdata_o = {{(CNT_W-1){1'b0}}, raw_q};
      REG_MASKED:           rdata_o = {{(CNT_W-1){1'b0}}, raw_q && ctrl_q[CB_IE]};
      default:              rdata_o = '0;
    endcase
  end

  assign irq_o   = raw_q && ctrl_q[CB_IE];
  assign ctrl_o  = ctrl_q;
  assign limit_o = limit_q;

  // R6: narrow counter keeps its upper half clear
  assert_narrow_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_WIDE] |-> (count_q[CNT_W-1:NARROW_W] == '0));

  // R5: an expiry leaves the raw flag set
  assert_expire_sets_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> raw_q);

  // R5: one-shot at zero holds
  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_EN] && ctrl_q[CB_ONESHOT] && at_zero && !wr_i) |=> (count_q == '0));

  // R7: clear without a competing expiry drops the flag
  assert_clear_drops_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire_ev) |=> !raw_q);

  // R4: a stopped channel does not count
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_EN] && !wr_i) |=> $stable(count_q));

endmodule

// File: rtl/dual_timer_top.sv
module dual_timer_top
  import dtmr_pkg::*;
#(
  parameter int AW   = 12,
  parameter int N_CH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  tick_i,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o
);

  localparam int CH_AW = 5;                       // 32-byte bank per channel
  localparam int IDX_W = AW - CH_AW;
  localparam logic [AW-1:0] ID_BASE = AW'((1 << AW) - 32);
  localparam logic [AW-1:0] CH_END  = AW'(N_CH << CH_AW);

  logic [IDX_W-1:0] ch_idx;
  chan_reg_e        reg_sel;
  logic             in_chan, in_id;
  logic [CNT_W-1:0] rd_mux;

  logic [CNT_W-1:0]  ch_rdata [N_CH];
  logic [CTRL_W-1:0] ch_ctrl  [N_CH];
  logic [CNT_W-1:0]  ch_limit [N_CH];
  logic [N_CH-1:0]   ch_irq;

  assign ch_idx  = bus_addr[AW-1:CH_AW];
  assign reg_sel = chan_reg_e'(bus_addr[CH_AW-1:2]);
  assign in_chan = (bus_addr < CH_END);
  assign in_id   = (bus_addr >= ID_BASE);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr && (ch_idx == IDX_W'(g));

    tmr_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i[g]),
      .wr_i    (ch_wr),
      .sel_i   (reg_sel),
      .wdata_i (bus_wdata),
      .rdata_o (ch_rdata[g]),
      .irq_o   (ch_irq[g]),
      .ctrl_o  (ch_ctrl[g]),
      .limit_o (ch_limit[g])
    );

    // R9: writes at or above the channel banks leave this channel alone
    assert_high_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !in_chan) |=> ($stable(ch_ctrl[g]) && $stable(ch_limit[g])));
  end

  always_comb begin
    rd_mux = '0;
    if (in_chan) begin
      for (int i = 0; i < N_CH; i++)
        if (ch_idx == IDX_W'(i)) rd_mux = ch_rdata[i];
    end else if (in_id) begin
      rd_mux = {{(CNT_W-8){1'b0}}, id_byte(bus_addr[CH_AW-1:2])};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq_o = |ch_irq;

  // R8: identification reads carry only a byte
  assert_id_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_id) |=> (bus_rdata[CNT_W-1:8] == '0));

  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_chan && !in_id) |=> (bus_rdata == '0));

  // R10: read data holds between reads
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/test_dual_timer_top.sv
module test_dual_timer_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tick_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #4 clk = ~clk;   // 125 MHz

  dual_timer_top i_dual_timer_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; logic [11:0] addr; } exp_t;
  exp_t sbq[$];
  exp_t cur;
  logic pend = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: a read sampled on an edge is valid by the following low phase
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10: read data with no expected item");
      end else begin
        cur = sbq.pop_front();
        chk($sformatf("%s @0x%03h", cur.tag, cur.addr), bus_rdata, cur.exp);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    exp_t it;
    it.exp = e; it.tag = tag; it.addr = a;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    sbq.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(int ch, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_i[ch] = 1'b1;
      @(negedge clk);
      tick_i[ch] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h008, 32'h20, "R1 ch0 ctrl");
    rd(12'h028, 32'h20, "R1 ch1 ctrl");
    rd(12'h004, 32'h0,  "R1 ch0 count");
    rd(12'h020, 32'h0,  "R1 ch1 limit");
    rd(12'h010, 32'h0,  "R1 ch0 raw");
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R3 limit write reloads (periodic, wide, stopped)
    wr(12'h008, 32'h62);
    wr(12'h000, 32'd5);
    rd(12'h004, 32'd5, "R3 count after limit write");
    rd(12'h000, 32'd5, "R2 limit readback");

    // R4/R5 periodic counting
    wr(12'h008, 32'hE2);
    tick(0, 3);
    rd(12'h004, 32'd2, "R4 count after 3 ticks");
    tick(0, 2);
    rd(12'h004, 32'd0, "R5 count at expiry");
    rd(12'h010, 32'd1, "R5 raw set");
    rd(12'h014, 32'd1, "R7 masked set");
    chk("R7 irq high", {31'b0, irq_o}, 32'h1);
    tick(0, 1);
    rd(12'h004, 32'd5, "R5 periodic reload");
    tick(1, 4);
    rd(12'h004, 32'd5, "R4 other channel tick ignored");
    wr(12'h00C, 32'h0);
    rd(12'h010, 32'd0, "R7 raw cleared");
    chk("R7 irq low after clear", {31'b0, irq_o}, 32'h0);

    // R3 background limit, R4 prescale on ch1
    wr(12'h038, 32'd100);
    rd(12'h024, 32'd0,   "R3 background limit no reload");
    rd(12'h020, 32'd100, "R2 ch1 limit");
    wr(12'h028, 32'hE6);
    tick(1, 15);
    rd(12'h024, 32'd100, "R4 div16 15 ticks");
    tick(1, 1);
    rd(12'h024, 32'd99,  "R4 div16 16th tick");
    wr(12'h028, 32'hEA);
    tick(1, 255);
    rd(12'h024, 32'd100, "R4 div256 255 ticks");
    tick(1, 1);
    rd(12'h024, 32'd99,  "R4 div256 256th tick");

    // R6 free-running widths
    wr(12'h008, 32'hA0);
    rd(12'h004, 32'h0000FFFF, "R6 narrow free reload");
    tick(0, 1);
    rd(12'h004, 32'h0000FFFE, "R6 narrow free decrement");
    wr(12'h000, 32'd7);
    rd(12'h004, 32'h0000FFFF, "R3 free-run limit write loads all ones");
    rd(12'h000, 32'd7,        "R3 limit stored in free-run");
    wr(12'h008, 32'hA2);
    rd(12'h004, 32'hFFFFFFFF, "R6 wide free reload");
    wr(12'h008, 32'hE0);
    wr(12'h000, 32'h00012345);
    rd(12'h004, 32'h00002345, "R6 narrow truncates limit");

    // R5 one-shot
    wr(12'h008, 32'h23);
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hA3);
    tick(0, 2);
    rd(12'h010, 32'd1, "R5 one-shot expiry");
    tick(0, 3);
    rd(12'h004, 32'd0, "R5 one-shot holds zero");
    wr(12'h00C, 32'h0);

    // R7 masking
    wr(12'h008, 32'hC2);
    tick(0, 2);
    rd(12'h010, 32'd1,  "R7 raw with mask off");
    rd(12'h014, 32'd0,  "R7 masked off");
    chk("R7 irq masked", {31'b0, irq_o}, 32'h0);
    rd(12'h008, 32'hC2, "R3 ctrl readback");

    // R7 OR of channels
    wr(12'h008, 32'hE2);
    chk("R7 irq ch0 only", {31'b0, irq_o}, 32'h1);
    wr(12'h028, 32'hE2);
    tick(1, 100);
    rd(12'h030, 32'd1, "R7 ch1 raw");
    wr(12'h00C, 32'h0);
    chk("R7 irq from ch1 after ch0 clear", {31'b0, irq_o}, 32'h1);
    wr(12'h02C, 32'h0);
    chk("R7 irq low after both clear", {31'b0, irq_o}, 32'h0);

    // R8 identification bytes
    for (int i = 0; i < 8; i++)
      rd(12'hFE0 + 12'(i*4), {24'h0, ids[i]}, "R8 id byte");

    // R9 test locations, high writes, unmapped
    rd(12'hF00, 32'h0, "R9 test loc 0");
    rd(12'hF04, 32'h0, "R9 test loc 1");
    wr(12'hF00, 32'hFF);
    wr(12'h040, 32'hFF);
    wr(12'h048, 32'h0);
    wr(12'h058, 32'hFFFF);
    rd(12'h008, 32'hE2, "R9 ch0 ctrl untouched");
    rd(12'h028, 32'hE2, "R9 ch1 ctrl untouched");
    rd(12'h000, 32'd2,  "R9 ch0 limit untouched");
    rd(12'h100, 32'h0,  "R9 unmapped 0x100");
    rd(12'h800, 32'h0,  "R9 unmapped 0x800");
    rd(12'h01C, 32'h0,  "R2 local 0x1C reads zero");

    // R10 hold between reads
    rd(12'hFE4, 32'h18, "R10 read value");
    @(negedge clk);
    bus_addr = 12'h008;
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 32'h18);

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10: actual=%0d pending expected=0", sbq.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule